// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block collects the interrupt causes of a 16550-style serial port, picks the single most urgent one, and presents it as an identification byte plus one active-high interrupt request. The receive buffer, the shift logic and the modem pin logic sit outside the block. They only feed it status: error flags, data-ready, the receive fill level and trigger threshold, a character-timeout flag, modem delta bits and a holding-register-empty flag.

The block keeps the 4-bit interrupt-enable register and the transmitter-empty pending flag. That flag is the only cause whose life cycle belongs to this unit. It is armed by emptying the transmit path or by turning its enable on. It is disarmed by a write of transmit data or by a host read of the identification byte that reported it. The identification code is a combinational function of the registered state and the present status inputs, so a strobe takes effect on the following cycle.

Top module: `uart_irq_ident`

## Requirements
- R1: Priority order, highest first: line-status error, character timeout, receive data, transmitter empty, modem status. The lower cause is reported only while all higher causes are inactive.
- R2: The line-status cause (code 4'h6) is active when enable bit 2 is set and any bit of `lsr_err` is set. The `lsr_err` bits are, from bit 3 down to bit 0: break, framing, parity, overrun.
- R3: The character-timeout cause (code 4'hC) is active when `tmo_pend` is high and enable bit 0 (receive data) is set. No other enable bit gates it.
- R4: The receive-data cause (code 4'h4) is active when enable bit 0 is set and `data_ready` is high, and either `fifo_en` is low or `rx_level >= rx_trig`.
- R5: The transmitter-empty cause (code 4'h2) is active when enable bit 1 is set and the pending flag is set. The pending flag clears one cycle after `thr_wr`, and one cycle after `iid_rd` if the identification code was 4'h2 in the cycle of the read.
- R6: A write that changes enable bit 1 loads the pending flag with (new bit 1 AND `thr_empty`). A rise while the holding register is empty therefore re-arms the flag, and clearing the enable clears it.
- R7: `tx_fifo_rst` sets the pending flag on the next cycle.
- R8: The modem-status cause (code 4'h0) is active when enable bit 3 is set and any bit of `msr_delta` is set.
- R9: With no active cause the code is 4'h1. `irq` is high exactly when the code differs from 4'h1.
- R10: `iid_byte[7:6]` equal 2'b11 while `fifo_en` is high and 2'b00 otherwise. `iid_byte[5:4]` are zero and `iid_byte[3:0]` carry the code.
- R11: An enable write stores only `ien_wdata[3:0]`. The upper four bits have no effect, and the stored value is visible on `ien_q` the next cycle.
- R12: After reset the enable register is 0, the pending flag is clear, and the code is 4'h1 with `irq` low.
- R13: When strobes coincide, the pending flag takes the first that applies: `thr_wr` (clear), `tx_fifo_rst` (set), an enable write changing bit 1 (R6), a clearing read (R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ien_wr | input | 1 | Enable-register write strobe |
| ien_wdata | input | 8 | Enable write data (bits 3:0 used) |
| fifo_en | input | 1 | FIFO mode active |
| lsr_err | input | 4 | Break, framing, parity, overrun flags |
| data_ready | input | 1 | Receive data available |
| rx_level | input | LVL_W | Receive FIFO fill count |
| rx_trig | input | LVL_W | Receive trigger threshold |
| tmo_pend | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status change bits |
| thr_empty | input | 1 | Transmit holding path empty |
| thr_wr | input | 1 | Host wrote transmit data |
| iid_rd | input | 1 | Host read the identification byte |
| tx_fifo_rst | input | 1 | Transmit FIFO reset strobe |
| ien_q | output | 4 | Stored enable bits |
| iid_byte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every strobe and status input is a settled level at the clock edge and that `rx_trig` never exceeds the FIFO depth. They also assume that strobes may coincide, so each clearing property excludes the strobes that outrank it under R13. The random stimulus changes inputs only on the falling edge and keeps `rx_level` and `rx_trig` within 0 to the depth. It holds `lsr_err` at zero most of the time so that the lower-priority causes are reached. It fires each strobe with low probability but also lets them collide.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;

  typedef enum logic [3:0] {
    IID_MSR  = 4'h0,
    IID_NONE = 4'h1,
    IID_THRE = 4'h2,
    IID_RXD  = 4'h4,
    IID_LSR  = 4'h6,
    IID_TMO  = 4'hC
  } iid_code_e;

  // Source slots, index 0 is the most urgent.
  localparam int NUM_SRC = 5;
  localparam int SRC_LSR = 0;
  localparam int SRC_TMO = 1;
  localparam int SRC_RXD = 2;
  localparam int SRC_THR = 3;
  localparam int SRC_MSR = 4;

  // Enable register bit positions.
  localparam int EN_RXD = 0;
  localparam int EN_THR = 1;
  localparam int EN_LSR = 2;
  localparam int EN_MSR = 3;
  localparam int EN_W   = 4;

  function automatic iid_code_e slot_code(input int idx);
    case (idx)
      SRC_LSR: return IID_LSR;
      SRC_TMO: return IID_TMO;
      SRC_RXD: return IID_RXD;
      SRC_THR: return IID_THRE;
      default: return IID_MSR;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_thre_track.sv
`timescale 1ns/1ps
module uart_irq_thre_track
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ien_wr,
  input  logic [EN_W-1:0] ien_wdata,
  input  logic            thr_empty,
  input  logic            thr_wr,
  input  logic            tx_fifo_rst,
  input  logic            iid_rd,
  input  logic            thre_reported,
  output logic [EN_W-1:0] ien_q,
  output logic            thre_pend
);

  logic thr_en_toggle;
  logic pend_nxt;

  assign thr_en_toggle = ien_wr && (ien_wdata[EN_THR] != ien_q[EN_THR]);

  always_comb begin
    pend_nxt = thre_pend;
    if (thr_wr)
      pend_nxt = 1'b0;
    else if (tx_fifo_rst)
      pend_nxt = 1'b1;
    else if (thr_en_toggle)
      pend_nxt = ien_wdata[EN_THR] && thr_empty;
    else if (iid_rd && thre_reported)
      pend_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q     <= '0;
      thre_pend <= 1'b0;
    end else begin
      if (ien_wr)
        ien_q <= ien_wdata;
      thre_pend <= pend_nxt;
    end
  end

endmodule

// File: rtl/uart_irq_src.sv
`timescale 1ns/1ps
module uart_irq_src
  import uart_irq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic               [EN_W-1:0] ien_q,
  input  logic                          fifo_en,
  input  logic                    [3:0] lsr_err,
  input  logic                          data_ready,
  input  logic              [LVL_W-1:0] rx_level,
  input  logic              [LVL_W-1:0] rx_trig,
  input  logic                          tmo_pend,
  input  logic                          thre_pend,
  input  logic                    [3:0] msr_delta,
  output logic            [NUM_SRC-1:0] req
);

  logic rx_level_met;

  assign rx_level_met = !fifo_en || (rx_level >= rx_trig);

  assign req[SRC_LSR] = ien_q[EN_LSR] && (|lsr_err);
  assign req[SRC_TMO] = ien_q[EN_RXD] && tmo_pend;
  assign req[SRC_RXD] = ien_q[EN_RXD] && data_ready && rx_level_met;
  assign req[SRC_THR] = ien_q[EN_THR] && thre_pend;
  assign req[SRC_MSR] = ien_q[EN_MSR] && (|msr_delta);

endmodule

// File: rtl/uart_irq_prio.sv
`timescale 1ns/1ps
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,
  output iid_code_e          code
);

  logic [NUM_SRC-1:0] higher;
  logic [NUM_SRC-1:0] grant;

  assign higher[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NUM_SRC; g++) begin : g_slot
      if (g > 0) begin : g_chain
        assign higher[g] = higher[g-1] | req[g-1];
      end
      assign grant[g] = req[g] & ~higher[g];
    end
  endgenerate

  always_comb begin
    code = IID_NONE;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i])
        code = slot_code(i);
    end
  end

endmodule

// File: rtl/uart_irq_ident.sv
`timescale 1ns/1ps
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter  int FIFO_DEPTH = 16,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ien_wr,
  input  logic [7:0]       ien_wdata,
  input  logic             fifo_en,
  input  logic [3:0]       lsr_err,
  input  logic             data_ready,
  input  logic [LVL_W-1:0] rx_level,
  input  logic [LVL_W-1:0] rx_trig,
  input  logic             tmo_pend,
  input  logic [3:0]       msr_delta,
  input  logic             thr_empty,
  input  logic             thr_wr,
  input  logic             iid_rd,
  input  logic             tx_fifo_rst,
  output logic [3:0]       ien_q,
  output logic [7:0]       iid_byte,
  output logic             irq
);

  logic [NUM_SRC-1:0] req;
  logic               thre_pend;
  iid_code_e          code;

  uart_irq_thre_track u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .ien_wr        (ien_wr),
    .ien_wdata     (ien_wdata[EN_W-1:0]),
    .thr_empty     (thr_empty),
    .thr_wr        (thr_wr),
    .tx_fifo_rst   (tx_fifo_rst),
    .iid_rd        (iid_rd),
    .thre_reported (code == IID_THRE),
    .ien_q         (ien_q),
    .thre_pend     (thre_pend)
  );

  uart_irq_src #(.LVL_W(LVL_W)) u_src (
    .ien_q      (ien_q),
    .fifo_en    (fifo_en),
    .lsr_err    (lsr_err),
    .data_ready (data_ready),
    .rx_level   (rx_level),
    .rx_trig    (rx_trig),
    .tmo_pend   (tmo_pend),
    .thre_pend  (thre_pend),
    .msr_delta  (msr_delta),
    .req        (req)
  );

  uart_irq_prio u_prio (
    .req  (req),
    .code (code)
  );

  assign iid_byte = {fifo_en, fifo_en, 2'b00, code};
  assign irq      = |req;

endmodule

// File: rtl/uart_irq_ident_chk.sv
`timescale 1ns/1ps
module uart_irq_ident_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ien_wr,
  input logic [7:0]       ien_wdata,
  input logic             fifo_en,
  input logic [3:0]       lsr_err,
  input logic             thr_wr,
  input logic             iid_rd,
  input logic             tx_fifo_rst,
  input logic [3:0]       ien_q,
  input logic [7:0]       iid_byte,
  input logic             irq
);

  // R2 / R1: an enabled line error always wins
  p_lsr_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q[2] && (|lsr_err)) |-> (iid_byte[3:0] == 4'h6));

  // R9: request line tracks the code
  p_irq_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iid_byte[3:0] != 4'h1));

  // R10: FIFO flag bits and reserved bits
  p_fifo_bits_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_byte[7:6] == {fifo_en, fifo_en}) && (iid_byte[5:4] == 2'b00));

  // R5: a write of transmit data removes the empty cause
  p_thr_wr_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (iid_byte[3:0] != 4'h2));

  // R5 / R13: a read that reported the empty cause removes it
  p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iid_rd && (iid_byte[3:0] == 4'h2) && !tx_fifo_rst && !ien_wr)
      |=> (iid_byte[3:0] != 4'h2));

  // R11: only the low nibble is stored
  p_ien_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ien_wr |=> (ien_q == $past(ien_wdata[3:0])));

  // R6: clearing the enable removes the empty cause
  p_en_off_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr && !ien_wdata[1]) |=> (iid_byte[3:0] != 4'h2));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.LVL_W(LVL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ien_wr      (ien_wr),
  .ien_wdata   (ien_wdata),
  .fifo_en     (fifo_en),
  .lsr_err     (lsr_err),
  .thr_wr      (thr_wr),
  .iid_rd      (iid_rd),
  .tx_fifo_rst (tx_fifo_rst),
  .ien_q       (ien_q),
  .iid_byte    (iid_byte),
  .irq         (irq)
);

// File: tb/uart_irq_ident_test.sv
`timescale 1ns/1ps
module uart_irq_ident_test;

  localparam int DEPTH = 16;
  localparam int LW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ien_wr = 0;
  logic [7:0]    ien_wdata = 0;
  logic          fifo_en = 0;
  logic [3:0]    lsr_err = 0;
  logic          data_ready = 0;
  logic [LW-1:0] rx_level = 0;
  logic [LW-1:0] rx_trig = 0;
  logic          tmo_pend = 0;
  logic [3:0]    msr_delta = 0;
  logic          thr_empty = 0;
  logic          thr_wr = 0;
  logic          iid_rd = 0;
  logic          tx_fifo_rst = 0;
  logic [3:0]    ien_q;
  logic [7:0]    iid_byte;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] m_ien = 0;
  logic       m_pend = 0;

  always #2 clk = ~clk;

  uart_irq_ident #(.FIFO_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .ien_wr(ien_wr), .ien_wdata(ien_wdata),
    .fifo_en(fifo_en), .lsr_err(lsr_err), .data_ready(data_ready),
    .rx_level(rx_level), .rx_trig(rx_trig), .tmo_pend(tmo_pend),
    .msr_delta(msr_delta), .thr_empty(thr_empty), .thr_wr(thr_wr),
    .iid_rd(iid_rd), .tx_fifo_rst(tx_fifo_rst), .ien_q(ien_q),
    .iid_byte(iid_byte), .irq(irq)
  );

  function automatic logic [3:0] want_code();
    if (m_ien[2] && (lsr_err != 0))                       return 4'h6;
    if (m_ien[0] && tmo_pend)                             return 4'hC;
    if (m_ien[0] && data_ready && (!fifo_en || rx_level >= rx_trig))
                                                          return 4'h4;
    if (m_ien[1] && m_pend)                               return 4'h2;
    if (m_ien[3] && (msr_delta != 0))                     return 4'h0;
    return 4'h1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Inputs are already applied after a falling edge; check, then advance the model.
  task automatic step(input string tag);
    logic [3:0] c;
    logic       p;
    #1;
    c = want_code();
    check(tag, {24'd0, iid_byte}, {24'd0, {fifo_en, fifo_en, 2'b00, c}});
    check("R9", {31'd0, irq}, {31'd0, c != 4'h1});
    check("R11", {28'd0, ien_q}, {28'd0, m_ien});
    p = m_pend;
    if (thr_wr) p = 1'b0;
    else if (tx_fifo_rst) p = 1'b1;
    else if (ien_wr && (ien_wdata[1] != m_ien[1])) p = ien_wdata[1] & thr_empty;
    else if (iid_rd && c == 4'h2) p = 1'b0;
    m_pend = p;
    if (ien_wr) m_ien = ien_wdata[3:0];
    @(negedge clk);
    ien_wr = 0; thr_wr = 0; iid_rd = 0; tx_fifo_rst = 0;
  endtask

  task automatic quiet();
    lsr_err = 0; tmo_pend = 0; data_ready = 0; msr_delta = 0;
    fifo_en = 0; rx_level = 0; rx_trig = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    step("R12");              // reset state held
    rst_n = 1'b1;
    step("R12");
    // R11: upper bits ignored
    ien_wr = 1; ien_wdata = 8'hF5; step("R11");
    step("R11");
    // R2 line error
    lsr_err = 4'b0100; step("R2");
    lsr_err = 4'b1000; tmo_pend = 1; step("R1");
    // R3 timeout, gated by bit 0
    lsr_err = 0; step("R3");
    ien_wr = 1; ien_wdata = 8'h04; step("R3");
    step("R3");
    // R4 receive data with FIFO threshold
    ien_wr = 1; ien_wdata = 8'h01; tmo_pend = 0; step("R4");
    data_ready = 1; fifo_en = 1; rx_level = 3; rx_trig = 4; step("R4");
    rx_level = 4; step("R4");
    fifo_en = 0; rx_level = 0; step("R10");
    quiet();
    // R6 enable rise with empty holding register
    thr_empty = 1; ien_wr = 1; ien_wdata = 8'h02; step("R6");
    step("R6");
    // R5 read clears
    iid_rd = 1; step("R5");
    step("R5");
    // R6 toggle off/on re-arms
    ien_wr = 1; ien_wdata = 8'h00; step("R6");
    ien_wr = 1; ien_wdata = 8'h02; step("R6");
    step("R6");
    // R5 write clears
    thr_wr = 1; step("R5");
    step("R5");
    // R6 rise while not empty
    ien_wr = 1; ien_wdata = 8'h00; step("R6");
    thr_empty = 0; ien_wr = 1; ien_wdata = 8'h0A; step("R6");
    step("R6");
    // R8 modem status below transmitter
    msr_delta = 4'b0010; step("R8");
    // R7 FIFO reset arms
    tx_fifo_rst = 1; step("R7");
    step("R1");
    // R13 write beats reset
    thr_wr = 1; tx_fifo_rst = 1; step("R13");
    step("R13");
    tx_fifo_rst = 1; iid_rd = 1; step("R13");
    step("R13");
    // Random mix
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = $urandom;
      ien_wr      = (r[2:0] == 0);
      ien_wdata   = $urandom;
      fifo_en     = r[3];
      lsr_err     = (r[5:4] == 0) ? r[9:6] : 4'h0;
      data_ready  = r[10];
      rx_level    = LW'(r[15:11] % (DEPTH + 1));
      rx_trig     = LW'(r[20:16] % (DEPTH + 1));
      tmo_pend    = (r[22:21] == 0);
      msr_delta   = r[23] ? r[27:24] : 4'h0;
      thr_empty   = r[28];
      r = $urandom;
      thr_wr      = (r[2:0] == 0);
      iid_rd      = (r[4:3] == 0);
      tx_fifo_rst = (r[8:5] == 0);
      step("R1");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule